// File: doc/BRIEF.md
# Stream packet traffic generator

This block is a synthesizable stream master that produces test packets for a downstream valid/ready port. A one-cycle start pulse captures the configuration and launches generation. The configuration sets the mode, the packet length in beats, the packet count, the idle cycles between beats and the idle cycles between packets. Every beat carries a predictable word: the packet index in the upper half and the beat index in the lower half. A scoreboard can therefore check each beat without a model of its own.

There are three modes. The first sends one packet. The second sends a programmed number of packets. The third repeats packets until a stop request arrives. A sticky done flag marks the end of a finite run.

The output follows the usual back-pressure rules. A beat transfers on a rising edge where valid and ready are both high. The generator never withdraws or alters a beat that has been offered. Ready may be held low for any number of cycles, and it may be high while valid is low.

Top module: `pkt_trafgen`

## Requirements
- R1: A synchronous active-high reset clears all counters, drives `m_tvalid` low and clears `done_o` by the next cycle, including in the middle of a run.
- R2: A start pulse with a valid configuration, sampled at a rising edge while idle, makes `m_tvalid` high right after that edge. Configuration inputs that change after that edge have no effect on the run.
- R3: Beat n of packet p carries `m_tdata = {p[15:0], n[15:0]}`. Both indices start at 0 for every run.
- R4: `m_tlast` is high exactly on beat `len_i-1` of each packet, and on every beat when the length is 1.
- R5: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values into the next cycle.
- R6: After a transfer that is not the last beat of a packet, `m_tvalid` stays low for exactly `beat_gap_i` cycles before the next beat. A value of 0 gives back-to-back beats.
- R7: After the last beat of a packet that is followed by another packet, `m_tvalid` stays low for exactly `pkt_gap_i` cycles. A value of 0 gives no gap.
- R8: Mode 1 (`mode_i = 2'd1`) sends exactly one packet. `done_o` is 0 until the final transfer and 1 on the cycle right after it.
- R9: Mode 2 (`mode_i = 2'd2`) sends exactly `count_i` packets. `done_o` behaves as in R8.
- R10: Mode 3 (`mode_i = 2'd3`) repeats packets and never sets `done_o`. When `stop_i` is high during a packet, that packet is completed and no further packet starts. When `stop_i` is high during the gap between packets, generation ends at once.
- R11: A start is ignored when the mode is 0, when the length is 0, when the mode is 2 with a count of 0, or when a run is already in progress. An ignored start produces no beat and leaves `done_o` unchanged.
- R12: `done_o` stays high until the next accepted start, which clears it. `done_o` and `m_tvalid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; configuration is sampled with it |
| stop_i | input | 1 | Stop request for the repeating mode |
| mode_i | input | 2 | 1 = one packet, 2 = counted packets, 3 = repeat |
| len_i | input | IDX_W | Beats per packet |
| count_i | input | IDX_W | Packet count in mode 2 |
| beat_gap_i | input | DLY_W | Idle cycles between beats |
| pkt_gap_i | input | DLY_W | Idle cycles between packets |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 2*IDX_W | Beat payload {packet index, beat index} |
| m_tlast | output | 1 | Last beat of a packet |
| done_o | output | 1 | Finite run completed |

## Verification
A wrong beat or packet index shows on the next transfer as a payload mismatch or a misplaced `m_tlast`. A gap counter that is off by one shows as a wrong number of idle cycles before the following beat. Lost back-pressure state shows in the next stalled cycle as changed data. A wrong end-of-run decision shows within one cycle of the final transfer, as missing or extra beats or a done flag that is early, late or absent. The bench corrupts the configuration inputs after every start, so a design that reads them live produces wrong payloads and lengths.

// File: rtl/pkt_trafgen_pkg.sv
package pkt_trafgen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } gen_state_e;

  localparam logic [1:0] MODE_ONE   = 2'd1;
  localparam logic [1:0] MODE_COUNT = 2'd2;
  localparam logic [1:0] MODE_LOOP  = 2'd3;
endpackage

// File: rtl/trafgen_gap_timer.sv
module trafgen_gap_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DLY_W-1:0] val_i,
  output logic             expired_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // one idle cycle remains: the next cycle may present a beat
  assign expired_o = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/trafgen_payload.sv
module trafgen_payload #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0]   pkt_i,
  input  logic [IDX_W-1:0]   beat_i,
  output logic [2*IDX_W-1:0] data_o
);
  assign data_o = {pkt_i, beat_i};
endmodule

// File: rtl/trafgen_ctrl.sv
module trafgen_ctrl
  import pkt_trafgen_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       mode_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic [IDX_W-1:0] count_i,
  input  logic [DLY_W-1:0] beat_gap_i,
  input  logic [DLY_W-1:0] pkt_gap_i,
  input  logic             tready_i,
  input  logic             gap_expired_i,
  output logic             gap_load_o,
  output logic [DLY_W-1:0] gap_val_o,
  output logic             valid_o,
  output logic             last_o,
  output logic [IDX_W-1:0] beat_o,
  output logic [IDX_W-1:0] pkt_o,
  output logic             done_o
);
  gen_state_e       state_q;
  logic [1:0]       mode_q;
  logic [IDX_W-1:0] len_q, count_q, beat_q, pkt_q;
  logic [DLY_W-1:0] bgap_q, pgap_q;
  logic             stop_q, done_q, in_pkt_gap_q;

  logic cfg_ok, xfer, last_beat, stop_now, last_pkt;

  assign cfg_ok = start_i && (mode_i != 2'd0) && (len_i != '0) &&
                  !((mode_i == MODE_COUNT) && (count_i == '0));
  assign xfer      = (state_q == ST_SEND) && tready_i;
  assign last_beat = (beat_q == len_q - 1'b1);
  assign stop_now  = stop_q || stop_i;
  assign last_pkt  = (mode_q == MODE_ONE) ||
                     ((mode_q == MODE_COUNT) && (pkt_q == count_q - 1'b1)) ||
                     ((mode_q == MODE_LOOP) && stop_now);

  assign gap_load_o = xfer && !(last_beat && last_pkt);
  assign gap_val_o  = last_beat ? pgap_q : bgap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_q       <= '0;
      len_q        <= '0;
      count_q      <= '0;
      bgap_q       <= '0;
      pgap_q       <= '0;
      beat_q       <= '0;
      pkt_q        <= '0;
      stop_q       <= 1'b0;
      done_q       <= 1'b0;
      in_pkt_gap_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cfg_ok) begin
            mode_q  <= mode_i;
            len_q   <= len_i;
            count_q <= count_i;
            bgap_q  <= beat_gap_i;
            pgap_q  <= pkt_gap_i;
            beat_q  <= '0;
            pkt_q   <= '0;
            stop_q  <= 1'b0;
            done_q  <= 1'b0;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if ((mode_q == MODE_LOOP) && stop_i) stop_q <= 1'b1;
          if (tready_i) begin
            if (last_beat) begin
              if (last_pkt) begin
                state_q <= ST_IDLE;
                done_q  <= (mode_q != MODE_LOOP);
              end else begin
                beat_q       <= '0;
                pkt_q        <= pkt_q + 1'b1;
                in_pkt_gap_q <= 1'b1;
                state_q      <= (pgap_q == '0) ? ST_SEND : ST_GAP;
              end
            end else begin
              beat_q       <= beat_q + 1'b1;
              in_pkt_gap_q <= 1'b0;
              state_q      <= (bgap_q == '0) ? ST_SEND : ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if ((mode_q == MODE_LOOP) && stop_i) stop_q <= 1'b1;
          if (in_pkt_gap_q && (mode_q == MODE_LOOP) && stop_now) begin
            state_q <= ST_IDLE;
          end else if (gap_expired_i) begin
            state_q <= ST_SEND;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == ST_SEND);
  assign last_o  = valid_o && last_beat;
  assign beat_o  = beat_q;
  assign pkt_o   = pkt_q;
  assign done_o  = done_q;
endmodule

// File: rtl/pkt_trafgen.sv
module pkt_trafgen #(
  parameter int IDX_W = 16,
  parameter int DLY_W = 8,
  localparam int DATA_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        mode_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  count_i,
  input  logic [DLY_W-1:0]  beat_gap_i,
  input  logic [DLY_W-1:0]  pkt_gap_i,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast,
  output logic              done_o
);
  logic             gap_load, gap_expired;
  logic [DLY_W-1:0] gap_val;
  logic [IDX_W-1:0] beat_idx, pkt_idx;

  trafgen_ctrl #(.IDX_W(IDX_W), .DLY_W(DLY_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .stop_i        (stop_i),
    .mode_i        (mode_i),
    .len_i         (len_i),
    .count_i       (count_i),
    .beat_gap_i    (beat_gap_i),
    .pkt_gap_i     (pkt_gap_i),
    .tready_i      (m_tready),
    .gap_expired_i (gap_expired),
    .gap_load_o    (gap_load),
    .gap_val_o     (gap_val),
    .valid_o       (m_tvalid),
    .last_o        (m_tlast),
    .beat_o        (beat_idx),
    .pkt_o         (pkt_idx),
    .done_o        (done_o)
  );

  trafgen_gap_timer #(.DLY_W(DLY_W)) u_gap (
    .clk       (clk),
    .rst       (rst),
    .load_i    (gap_load),
    .val_i     (gap_val),
    .expired_o (gap_expired)
  );

  trafgen_payload #(.IDX_W(IDX_W)) u_payload (
    .pkt_i  (pkt_idx),
    .beat_i (beat_idx),
    .data_o (m_tdata)
  );
endmodule

// File: rtl/pkt_trafgen_checker.sv
module pkt_trafgen_checker #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             m_tvalid,
  input logic             m_tready,
  input logic [2*IDX_W-1:0] m_tdata,
  input logic             m_tlast,
  input logic             done_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!m_tvalid && !done_o));

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_beat_step_R3: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && m_tready && !m_tlast) |=>
      (!m_tvalid || (m_tdata[IDX_W-1:0] == IDX_W'($past(m_tdata[IDX_W-1:0]) + 1'b1))));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(m_tvalid && m_tready && m_tlast));

  assert_done_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  assert_done_excl_valid_R12: assert property (@(posedge clk) disable iff (rst)
    !(done_o && m_tvalid));
endmodule

bind pkt_trafgen pkt_trafgen_checker #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tdata  (m_tdata),
  .m_tlast  (m_tlast),
  .done_o   (done_o)
);

// File: tb/tb_pkt_trafgen.sv
module tb_pkt_trafgen;
  localparam int IDX_W = 16;
  localparam int DLY_W = 8;

  typedef struct packed {
    logic [1:0]       mode;
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] cnt;
    logic [DLY_W-1:0] bgap;
    logic [DLY_W-1:0] pgap;
    logic [1:0]       rdy;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 16'd4, 16'd0, 8'd0, 8'd0, 2'd0},
    '{2'd1, 16'd3, 16'd0, 8'd2, 8'd0, 2'd1},
    '{2'd2, 16'd2, 16'd3, 8'd0, 8'd3, 2'd0},
    '{2'd2, 16'd3, 16'd2, 8'd1, 8'd2, 2'd2},
    '{2'd2, 16'd1, 16'd4, 8'd0, 8'd0, 2'd1},
    '{2'd3, 16'd2, 16'd0, 8'd0, 8'd1, 2'd0},
    '{2'd3, 16'd1, 16'd0, 8'd1, 8'd2, 2'd1}
  };

  logic clk = 1'b0;
  logic rst, start_i, stop_i, m_tready;
  logic [1:0] mode_i;
  logic [IDX_W-1:0] len_i, count_i;
  logic [DLY_W-1:0] beat_gap_i, pkt_gap_i;
  logic m_tvalid, m_tlast, done_o;
  logic [2*IDX_W-1:0] m_tdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pkt_trafgen #(.IDX_W(IDX_W), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .mode_i(mode_i),
    .len_i(len_i), .count_i(count_i), .beat_gap_i(beat_gap_i), .pkt_gap_i(pkt_gap_i),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_case(input vec_t v, input bit stop_in_gap);
    int exp_pkts, pkt, beat, hs, idle, gap, gap_exp;
    bit gap_open, final_hs, seen_final, bad_done, prev_stall, is_hs, prev_last;
    logic [2*IDX_W-1:0] prev_data;
    exp_pkts = (v.mode == 2'd1) ? 1 : (v.mode == 2'd2) ? int'(v.cnt) : (stop_in_gap ? 1 : 3);
    pkt = 0; beat = 0; hs = 0; idle = 0; gap = 0; gap_exp = 0;
    gap_open = 0; final_hs = 0; seen_final = 0; bad_done = 0; prev_stall = 0;
    prev_last = 0; prev_data = '0;
    @(negedge clk);
    mode_i = v.mode; len_i = v.len; count_i = v.cnt;
    beat_gap_i = v.bgap; pkt_gap_i = v.pgap; start_i = 1'b1; m_tready = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // R2: scramble the configuration; the run must not notice
    mode_i = 2'd0; len_i = 16'd9; count_i = 16'd7; beat_gap_i = 8'd5; pkt_gap_i = 8'd4;
    check(m_tvalid == 1'b1, "R2 valid right after start", longint'(m_tvalid), 1);
    check(done_o == 1'b0, "R12 done cleared by start", longint'(done_o), 0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (final_hs) begin
        check(done_o && !m_tvalid, "R8 R9 done one cycle after final beat", longint'(done_o), 1);
        final_hs = 0;
        seen_final = 1;
      end
      if (done_o && !seen_final) bad_done = 1;
      if (prev_stall)
        check(m_tvalid && m_tdata == prev_data && m_tlast == prev_last,
              "R5 beat held under stall", longint'(m_tdata), longint'(prev_data));
      start_i = 1'b0;
      stop_i = 1'b0;
      m_tready = (v.rdy == 2'd0) || ((cyc % (int'(v.rdy) + 1)) == 0);
      // a second start in mid-run must be ignored (R11)
      if (hs == 1 && m_tvalid) begin
        start_i = 1'b1; mode_i = 2'd1; len_i = 16'd5;
      end
      if (!m_tvalid) begin
        idle++;
        if (gap_open) gap++;
        if (stop_in_gap && hs == 1 && gap == 2) stop_i = 1'b1;
      end else begin
        idle = 0;
        if (gap_open) begin
          check(gap == gap_exp, gap_exp == int'(v.pgap) && beat == 0 ?
                "R7 packet gap" : "R6 beat gap", gap, gap_exp);
          gap_open = 0;
        end
      end
      is_hs = m_tvalid && m_tready;
      if (is_hs) begin
        check(m_tdata == {pkt[15:0], beat[15:0]}, "R3 payload",
              longint'(m_tdata), longint'({pkt[15:0], beat[15:0]}));
        check(m_tlast == (beat == int'(v.len) - 1), "R4 last marker",
              longint'(m_tlast), longint'(beat == int'(v.len) - 1));
        if (v.mode == 2'd3 && !stop_in_gap && pkt == 2 && beat == 0) stop_i = 1'b1;
        hs++;
        gap_open = 1;
        gap = 0;
        if (beat == int'(v.len) - 1) begin
          gap_exp = int'(v.pgap);
          if (v.mode != 2'd3 && pkt == exp_pkts - 1) final_hs = 1;
          beat = 0;
          pkt++;
        end else begin
          gap_exp = int'(v.bgap);
          beat++;
        end
      end
      prev_stall = m_tvalid && !m_tready;
      prev_data = m_tdata;
      prev_last = m_tlast;
      if (hs > 0 && idle >= 30) break;
      @(negedge clk);
    end
    m_tready = 1'b0;
    stop_i = 1'b0;
    start_i = 1'b0;
    check(hs == exp_pkts * int'(v.len), v.mode == 2'd3 ? "R10 beat total" :
          (v.mode == 2'd2 ? "R9 beat total" : "R8 beat total"), hs, exp_pkts * int'(v.len));
    check(!bad_done && (done_o == (v.mode != 2'd3)),
          v.mode == 2'd3 ? "R10 done never set" : "R8 R9 done timing",
          longint'(done_o), longint'(v.mode != 2'd3));
  endtask

  task automatic bad_start(input logic [1:0] m, input logic [IDX_W-1:0] l,
                           input logic [IDX_W-1:0] c, input bit done_before);
    bit any_valid;
    any_valid = 0;
    @(negedge clk);
    mode_i = m; len_i = l; count_i = c; beat_gap_i = 0; pkt_gap_i = 0;
    m_tready = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (m_tvalid) any_valid = 1;
      @(negedge clk);
    end
    check(!any_valid, "R11 invalid start gives no beat", longint'(any_valid), 0);
    check(done_o == done_before, "R11 done unchanged", longint'(done_o), longint'(done_before));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; stop_i = 1'b0; m_tready = 1'b0;
    mode_i = 2'd0; len_i = '0; count_i = '0; beat_gap_i = '0; pkt_gap_i = '0;
    repeat (3) @(negedge clk);
    check(!m_tvalid && !done_o, "R1 reset state", longint'({m_tvalid, done_o}), 0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) run_case(VECS[k], 1'b0);

    // finite run leaves done high, then invalid starts must not touch it
    run_case('{2'd1, 16'd2, 16'd0, 8'd0, 8'd0, 2'd0}, 1'b0);
    repeat (10) @(negedge clk);
    check(done_o == 1'b1, "R12 done held while idle", longint'(done_o), 1);
    bad_start(2'd0, 16'd3, 16'd1, 1'b1);
    bad_start(2'd1, 16'd0, 16'd1, 1'b1);
    bad_start(2'd2, 16'd3, 16'd0, 1'b1);

    // R10: stop during the gap between packets ends at once
    run_case('{2'd3, 16'd1, 16'd0, 8'd0, 8'd5, 2'd0}, 1'b1);

    // R1: reset in the middle of a repeating run
    @(negedge clk);
    mode_i = 2'd3; len_i = 16'd4; count_i = 0; beat_gap_i = 1; pkt_gap_i = 1;
    m_tready = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!m_tvalid && !done_o, "R1 reset mid-run", longint'(m_tvalid), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(!m_tvalid, "R1 stays idle after reset", longint'(m_tvalid), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule